// File: doc/BRIEF.md
# Peripheral Event Routing Fabric

This block carries single-cycle event pulses from peripheral generators (timer ticks, comparator trips, converter completions) to peripheral user inputs. No processor or bus transaction takes part. Eight independent channels each pick one of sixteen generator lines. Each of eight user inputs subscribes to one channel, and several users may listen to the same channel. Every pulse is delivered to each subscribed user after a fixed two-cycle delay.

Configuration uses a plain write port. A write either sets a channel's generator selection or sets a user's channel subscription. Per-channel status pins report whether an event is in flight and whether the generator fired on consecutive cycles.

The event path has no valid/ready handshake and no back-pressure. The fabric never stalls and never drops an event, so a destination must accept a pulse in the cycle it arrives. All pins are plain control and status signals.

Top module: `evr_fabric`

## Requirements
- R1: The fabric has 8 channels, 16 generator inputs and 8 user outputs. An event on one channel never appears on a user attached only to another channel.
- R2: A generator pulse held high during cycle t on a channel that selects it appears on every user subscribed to that channel during cycle t+2 only. It is high for exactly one cycle per input cycle.
- R3: Generator selection code 0 disables a channel. Code v in 1..16 selects `gen_in[v-1]`. Codes 17..31 disable the channel.
- R4: User subscription code 0 means no connection. Code v in 1..8 selects channel v-1. Codes 9..15 mean no connection. Several users may share one channel.
- R5: A write with `cfg_we`=1 and `cfg_user`=0 stores `cfg_val` as the generator code of channel `cfg_idx`. A write with `cfg_user`=1 stores `cfg_val[3:0]` as the subscription code of user `cfg_idx`. A write becomes effective for generator pulses in the cycle after the write cycle.
- R6: An event in flight completes with the routing that was in effect when it was captured. A subscription write in the same cycle as the generator pulse does not redirect that pulse.
- R7: No event is lost. A generator held high for n consecutive cycles yields n consecutive output cycles at each subscribed user.
- R8: `ch_busy[c]` is high during cycle t+1 for a pulse on channel c in cycle t, and low otherwise.
- R9: `ch_overrun[c]` sets when channel c captures pulses on two consecutive cycles. It stays set until reset or until any generator-code write to channel c. A lone pulse never sets it.
- R10: A synchronous active-low reset clears all routing codes, pipeline stages, busy flags and overrun flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_user | input | 1 | Write target: 0 channel generator code, 1 user subscription code |
| cfg_idx | input | 3 | Channel or user index |
| cfg_val | input | 5 | Code to store |
| gen_in | input | 16 | Generator event pulses |
| usr_evt | output | 8 | Event pulses to user inputs |
| ch_busy | output | 8 | Event in flight per channel |
| ch_overrun | output | 8 | Sticky consecutive-pulse flag per channel |

## Verification
The assertions check properties that must hold on every cycle:
- a user pulse is always preceded by a busy channel;
- a busy channel is always preceded by some generator activity;
- overrun only rises after a busy cycle;
- overrun only falls after a channel write;
- reset empties the outputs.

Only the directed scenarios can show the things that depend on the programmed routing:
- the exact two-cycle arrival at the correct users;
- the decoding of out-of-range codes;
- the use of the capture-time routing by an in-flight event;
- delivery of a consecutive burst with nothing lost, including an overcurrent trip that halts a modelled PWM timer.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic {
    TGT_CHAN = 1'b0,
    TGT_USER = 1'b1
  } cfg_tgt_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs #(
  parameter int NUM_CH  = 8,
  parameter int NUM_GEN = 16,
  parameter int NUM_USR = 8,
  parameter int IDXW    = 3,
  parameter int CVW     = 5,
  localparam int GSW    = $clog2(NUM_GEN + 1),
  localparam int USW    = $clog2(NUM_CH + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic                             cfg_user,
  input  logic [IDXW-1:0]                  cfg_idx,
  input  logic [CVW-1:0]                   cfg_val,
  output logic [NUM_CH-1:0][GSW-1:0]       gen_sel,
  output logic [NUM_USR-1:0][USW-1:0]      usr_sel,
  output logic [NUM_CH-1:0]                ch_clr
);
  import evr_pkg::*;

  cfg_tgt_e tgt;
  logic     hit_ch;
  logic     hit_usr;

  assign tgt     = cfg_tgt_e'(cfg_user);
  assign hit_ch  = cfg_we && (tgt == TGT_CHAN) && (int'(cfg_idx) < NUM_CH);
  assign hit_usr = cfg_we && (tgt == TGT_USER) && (int'(cfg_idx) < NUM_USR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_sel <= '0;
      usr_sel <= '0;
    end else begin
      if (hit_ch)  gen_sel[cfg_idx] <= cfg_val[GSW-1:0];
      if (hit_usr) usr_sel[cfg_idx] <= cfg_val[USW-1:0];
    end
  end

  // A generator-code write also clears that channel's sticky overrun.
  always_comb begin
    ch_clr = '0;
    if (hit_ch) ch_clr[cfg_idx] = 1'b1;
  end
endmodule

// File: rtl/evr_chan_slice.sv
module evr_chan_slice #(
  parameter int NUM_GEN = 16,
  localparam int GSW    = $clog2(NUM_GEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GSW-1:0]     src_sel,
  input  logic [NUM_GEN-1:0] gen_in,
  input  logic               clr_ovr,
  output logic               hit_q,
  output logic               ovr_q
);
  logic hit_d;

  // Codes 1..NUM_GEN pick a line; 0 and anything above never match.
  always_comb begin
    hit_d = 1'b0;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (src_sel == GSW'(g + 1)) hit_d = gen_in[g];
    end
  end

  // Stage 1 of the event pipeline, plus the overrun detector.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      ovr_q <= (ovr_q & ~clr_ovr) | (hit_d & hit_q);
    end
  end
endmodule

// File: rtl/evr_user_stage.sv
module evr_user_stage #(
  parameter int NUM_CH  = 8,
  parameter int NUM_USR = 8,
  localparam int USW    = $clog2(NUM_CH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0]           ch_hit,
  input  logic [NUM_USR-1:0][USW-1:0] usr_sel,
  output logic [NUM_USR-1:0]          usr_evt
);
  // Snapshot of the subscriptions taken on the capture edge, so an
  // event leaving stage 1 uses the routing seen when it entered.
  logic [NUM_USR-1:0][USW-1:0] sel_snap;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_snap <= '0;
    else        sel_snap <= usr_sel;
  end

  for (genvar u = 0; u < NUM_USR; u++) begin : g_usr
    logic pick;
    always_comb begin
      pick = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel_snap[u] == USW'(c + 1)) pick = ch_hit[c];
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) usr_evt[u] <= 1'b0;
      else        usr_evt[u] <= pick;
    end
  end
endmodule

// File: rtl/evr_fabric.sv
module evr_fabric #(
  parameter int NUM_CH  = 8,
  parameter int NUM_GEN = 16,
  parameter int NUM_USR = 8,
  localparam int GSW    = $clog2(NUM_GEN + 1),
  localparam int USW    = $clog2(NUM_CH + 1),
  localparam int IDXW   = $clog2(evr_pkg::max2(NUM_CH, NUM_USR)),
  localparam int CVW    = evr_pkg::max2(GSW, USW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_user,
  input  logic [IDXW-1:0]    cfg_idx,
  input  logic [CVW-1:0]     cfg_val,
  input  logic [NUM_GEN-1:0] gen_in,
  output logic [NUM_USR-1:0] usr_evt,
  output logic [NUM_CH-1:0]  ch_busy,
  output logic [NUM_CH-1:0]  ch_overrun
);
  logic [NUM_CH-1:0][GSW-1:0]  gen_sel;
  logic [NUM_USR-1:0][USW-1:0] usr_sel;
  logic [NUM_CH-1:0]           ch_clr;
  logic [NUM_CH-1:0]           ch_hit;

  evr_cfg_regs #(
    .NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN), .NUM_USR(NUM_USR),
    .IDXW(IDXW), .CVW(CVW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_user(cfg_user),
    .cfg_idx(cfg_idx), .cfg_val(cfg_val),
    .gen_sel(gen_sel), .usr_sel(usr_sel), .ch_clr(ch_clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evr_chan_slice #(.NUM_GEN(NUM_GEN)) u_slice (
      .clk(clk), .rst_n(rst_n), .src_sel(gen_sel[c]), .gen_in(gen_in),
      .clr_ovr(ch_clr[c]), .hit_q(ch_hit[c]), .ovr_q(ch_overrun[c])
    );
  end

  evr_user_stage #(.NUM_CH(NUM_CH), .NUM_USR(NUM_USR)) u_usr (
    .clk(clk), .rst_n(rst_n), .ch_hit(ch_hit), .usr_sel(usr_sel),
    .usr_evt(usr_evt)
  );

  assign ch_busy = ch_hit;
endmodule

// File: rtl/evr_fabric_chk.sv
module evr_fabric_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_GEN = 16,
  parameter int NUM_USR = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               cfg_user,
  input logic [NUM_GEN-1:0] gen_in,
  input logic [NUM_USR-1:0] usr_evt,
  input logic [NUM_CH-1:0]  ch_busy,
  input logic [NUM_CH-1:0]  ch_overrun
);
  // R2: a user pulse needs an event in stage 1 one cycle earlier
  assert_user_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_evt != '0) |-> ($past(ch_busy) != '0));

  // R8: busy needs generator activity one cycle earlier
  assert_busy_after_gen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_busy != '0) |-> ($past(gen_in) != '0));

  // R9: a newly set overrun bit needs that channel busy one cycle earlier
  assert_overrun_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_overrun & ~$past(ch_overrun)) != '0) |->
      (((ch_overrun & ~$past(ch_overrun)) & ~$past(ch_busy)) == '0));

  // R9: overrun bits only fall after a channel-code write
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(cfg_we) && !$past(cfg_user)) |->
      (($past(ch_overrun) & ~ch_overrun) == '0));

  // R10: reset empties every output
  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> (usr_evt == '0 && ch_busy == '0 && ch_overrun == '0));
endmodule

bind evr_fabric evr_fabric_chk #(
  .NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN), .NUM_USR(NUM_USR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_user(cfg_user),
  .gen_in(gen_in), .usr_evt(usr_evt), .ch_busy(ch_busy),
  .ch_overrun(ch_overrun)
);

// File: tb/tb_evr_fabric.sv
`timescale 1ns/1ps
module tb_evr_fabric;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_user = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [4:0]  cfg_val = '0;
  logic [15:0] gen_in = '0;
  logic [7:0]  usr_evt, ch_busy, ch_overrun;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // PWM timer model: its run flag drops when user 3 sees a stop event.
  logic pwm_run = 1'b0;
  logic pwm_arm = 1'b0;
  always @(posedge clk) begin
    if (pwm_arm)         pwm_run <= 1'b1;
    else if (usr_evt[3]) pwm_run <= 1'b0;
  end

  always #4 clk = ~clk;

  evr_fabric dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_user(cfg_user),
    .cfg_idx(cfg_idx), .cfg_val(cfg_val), .gen_in(gen_in),
    .usr_evt(usr_evt), .ch_busy(ch_busy), .ch_overrun(ch_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic user, input int idx, input int val);
    cfg_we = 1'b1; cfg_user = user; cfg_idx = 3'(idx); cfg_val = 5'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8; i++) wr(1'b0, i, 0);
    for (int i = 0; i < 8; i++) wr(1'b1, i, 0);
  endtask

  // One-cycle pulse, then check busy at t+1 and users at t+2 only.
  task automatic pulse(input string req, input logic [15:0] mask,
                       input logic [7:0] exp_busy, input logic [7:0] exp_usr);
    gen_in = mask;
    @(negedge clk);
    gen_in = '0;
    chk({req, " R8 busy t+1"}, 32'(ch_busy), 32'(exp_busy));
    chk({req, " R2 no early"}, 32'(usr_evt), 32'h0);
    @(negedge clk);
    chk({req, " R2 users t+2"}, 32'(usr_evt), 32'(exp_usr));
    chk({req, " R8 busy clear"}, 32'(ch_busy), 32'h0);
    @(negedge clk);
    chk({req, " R2 one cycle"}, 32'(usr_evt), 32'h0);
  endtask

  task automatic t_reset();
    chk("R10 usr", 32'(usr_evt), 32'h0);
    chk("R10 busy", 32'(ch_busy), 32'h0);
    chk("R10 ovr", 32'(ch_overrun), 32'h0);
    pulse("R10 R3 R4 defaults", 16'hFFFF, 8'h00, 8'h00);
  endtask

  task automatic t_basic();
    clear_all();
    wr(1'b0, 0, 3);  // ch0 <- gen_in[2]
    wr(1'b0, 1, 16); // ch1 <- gen_in[15]
    wr(1'b1, 0, 1);  // users 0,5 on ch0
    wr(1'b1, 5, 1);
    wr(1'b1, 2, 2);  // user 2 on ch1
    pulse("R1 R4 share", 16'h0004, 8'h01, 8'h21);
    pulse("R3 top code", 16'h8000, 8'h02, 8'h04);
    pulse("R3 unselected", 16'h7FFB, 8'h00, 8'h00);
    chk("R9 lone pulse", 32'(ch_overrun), 32'h0);
  endtask

  task automatic t_codes();
    clear_all();
    wr(1'b0, 1, 20); // out of range: disabled
    wr(1'b0, 4, 0);  // disabled
    wr(1'b0, 2, 1);  // ch2 <- gen_in[0]
    wr(1'b1, 7, 12); // out of range: no connection
    wr(1'b1, 6, 3);  // user 6 on ch2
    wr(1'b1, 1, 0);  // no connection
    pulse("R3 R4 range", 16'hFFFF, 8'h04, 8'h40);
  endtask

  task automatic t_motor();
    clear_all();
    wr(1'b0, 5, 10); // overcurrent comparator on gen_in[9] -> ch5
    wr(1'b1, 3, 6);  // PWM stop input (user 3) on ch5
    pwm_arm = 1'b1;
    @(negedge clk);
    pwm_arm = 1'b0;
    chk("R5 pwm armed", 32'(pwm_run), 32'h1);
    pulse("R5 motor trip", 16'h0200, 8'h20, 8'h08);
    chk("R2 pwm halted", 32'(pwm_run), 32'h0);
  endtask

  task automatic t_inflight();
    clear_all();
    wr(1'b0, 0, 1); // ch0 <- gen_in[0]
    wr(1'b1, 0, 1); // user 0 on ch0
    // Re-subscribe user 0 to idle ch1 in the pulse cycle.
    cfg_we = 1'b1; cfg_user = 1'b1; cfg_idx = 3'd0; cfg_val = 5'd2;
    pulse("R6 old route", 16'h0001, 8'h01, 8'h01);
    cfg_we = 1'b0;
    pulse("R6 new route", 16'h0001, 8'h01, 8'h00);
    // A generator-code write applies to a pulse right after it.
    wr(1'b1, 0, 1);
    wr(1'b0, 0, 2);
    pulse("R5 next cycle", 16'h0002, 8'h01, 8'h01);
  endtask

  task automatic t_burst();
    clear_all();
    wr(1'b0, 2, 4); // ch2 <- gen_in[3]
    wr(1'b1, 4, 3); // user 4 on ch2
    gen_in = 16'h0008;
    @(negedge clk);
    chk("R7 burst early", 32'(usr_evt), 32'h0);
    @(negedge clk);
    chk("R7 burst 1", 32'(usr_evt), 32'h10);
    chk("R9 overrun set", 32'(ch_overrun), 32'h04);
    @(negedge clk);
    gen_in = '0;
    chk("R7 burst 2", 32'(usr_evt), 32'h10);
    @(negedge clk);
    chk("R7 burst 3", 32'(usr_evt), 32'h10);
    @(negedge clk);
    chk("R7 burst end", 32'(usr_evt), 32'h0);
    chk("R9 sticky", 32'(ch_overrun), 32'h04);
    wr(1'b1, 4, 3);
    chk("R9 user write keeps", 32'(ch_overrun), 32'h04);
    wr(1'b0, 2, 4);
    chk("R9 chan write clears", 32'(ch_overrun), 32'h0);
  endtask

  task automatic t_reset_mid();
    gen_in = 16'h0008;
    @(negedge clk);
    gen_in = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 flush", 32'(usr_evt | ch_busy), 32'h0);
    pulse("R10 routing cleared", 16'h0008, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_codes();
    t_motor();
    t_inflight();
    t_burst();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule